// File: doc/BRIEF.md
# Conversion Sequencer with Ready and Error Flags

This block schedules conversions for a sampled-data converter and keeps the two flags that software watches: a ready flag and an error flag. A mode field selects continuous conversion, a single conversion, or power-down. A rate field and a clock-divide field set the update period. A channel input names what is being converted. A free-running counter of system clocks decides when each new result is written into the data register. A plain signed sample port stands in for the modulator and filter. Each written result is clamped to the 16-bit range and stored in offset-binary form.

The ready flag goes low when a fresh result lands in the data register. It goes high again when the result has been read. It also goes high a fixed number of clocks before each update, so that a reader keeps away from a register that is about to change. Writing the mode, or changing the channel while converting, restarts the timing. The first result after a restart takes two update periods. Each result after that takes one period.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the data register reads 0x0000, ready is 1, error is 0, the reported channel is 0, and the block is converting.
- R2: A mode write of 2'b00 starts continuous conversion and 2'b10 starts a single conversion. Both 2'b11 and the reserved code 2'b01 put the block in power-down: ready is set, the active output drops, and the data register never changes.
- R3: After a restart the first result is written 2*P clocks after the restart edge, and later results follow every P clocks. P = floor(TICKS_X10 / T) << div, where T is the rate in tenths of a hertz for rate codes 0..7: 1200, 1000, 333, 200, 166, 167, 133, 95.
- R4: The clock-divide code d (0..3) multiplies every update period, the first one included, by 2^d.
- R5: Ready goes to 0 on the edge that writes a result, and goes to 1 exactly PRE_CLKS clocks before each scheduled write.
- R6: A one-clock dataRead pulse sets ready on the next edge, unless a result is written on that same edge.
- R7: A mode write sets ready on the next edge. A change of chanIn while converting also restarts the timing and sets ready. convChan reports chanIn one clock later.
- R8: In single mode exactly one result is written. The block then goes inactive and holds that result, with ready at 0, until a read or a new mode write.
- R9: A sample above 32767 is stored as 0xFFFF and a sample below -32768 is stored as 0x0000. Either case sets the error flag. An in-range result clears the flag. A mode write of 2'b00 or 2'b10 clears it.
- R10: An in-range sample s is stored as s + 0x8000, so -32768 gives 0x0000, 0 gives 0x8000 and 32767 gives 0xFFFF.
- R11: When readBusy is 1 and streamRd is 0 at a scheduled write, the new result is discarded and the register keeps the old word. When streamRd is 1, the new result replaces the old one regardless of readBusy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | One-clock strobe: mode register written with modeIn |
| modeIn | input | 2 | 00 continuous, 01 reserved, 10 single, 11 power-down |
| rateIn | input | 3 | Update-rate code |
| divIn | input | 2 | Clock-divide code (factor 2^divIn) |
| chanIn | input | 2 | Selected channel |
| sampleIn | input | SAMPLE_W | Raw signed sample from the modulator stub |
| dataRead | input | 1 | One-clock strobe: data register read completed |
| readBusy | input | 1 | A normal read of the data register is in progress |
| streamRd | input | 1 | Continuous-read mode: words are read once and may be replaced |
| dataOut | output | 16 | Data register, offset binary |
| readyOut | output | 1 | Ready flag, 0 when an unread result is available |
| errOut | output | 1 | Clamp error flag |
| convChan | output | 2 | Channel being converted |
| convActive | output | 1 | Converter is running (not powered down or holding) |

## Verification
The bench counts edges from every restart and samples on either side of the write edge. A design that reloads one period instead of two after a restart writes its first result half-way through the window. A design that ignores the divide code writes 2^d times too early. The clamp points are probed at exactly 32767, -32768 and one beyond each. An off-by-one in the comparison shows up as a wrong error flag, or as a wrapped code where the clamped value belongs. The bench also checks the held single-mode result, the power-down codes including the reserved one, and a channel change in mid-period. A sequencer that lets the old schedule fire, or that keeps converting after its single result, changes the register when it must not.

// File: rtl/convseq_pkg.sv
`timescale 1ns/1ps
package convseq_pkg;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_OFF    = 2'b11
  } modeE;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_RUN  = 2'b01,
    ST_HOLD = 2'b10
  } stateE;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic clearErr;
  } strobeT;

  localparam logic [2:0] DEF_RATE = 3'd4;

  // update rate in tenths of a hertz for each rate code
  function automatic int unsigned rateTenths(input logic [2:0] sel);
    case (sel)
      3'd0:    rateTenths = 1200;
      3'd1:    rateTenths = 1000;
      3'd2:    rateTenths = 333;
      3'd3:    rateTenths = 200;
      3'd4:    rateTenths = 166;
      3'd5:    rateTenths = 167;
      3'd6:    rateTenths = 133;
      default: rateTenths = 95;
    endcase
  endfunction

endpackage

// File: rtl/cs_timebase.sv
`timescale 1ns/1ps
module cs_timebase
  import convseq_pkg::*;
#(
  parameter int unsigned TICKS_X10 = 100_000_000,
  parameter int unsigned PRE_CLKS  = 1000,
  parameter int unsigned CNT_W     = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [2:0] rateSel,
  input  logic [1:0] divSel,
  output logic       due,
  output logic       early
);

  localparam logic [CNT_W-1:0] DEF_FIRST =
    CNT_W'(2 * (TICKS_X10 / rateTenths(DEF_RATE)) - 1);

  logic [CNT_W-1:0] perTab [8];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] basePer;
  logic [CNT_W-1:0] firstPer;

  for (genvar g = 0; g < 8; g++) begin : g_per
    assign perTab[g] = CNT_W'(TICKS_X10 / rateTenths(3'(g)));
  end

  always_comb begin
    basePer  = perTab[rateSel] << divSel;
    firstPer = basePer << 1;
    due      = run && (cnt == '0);
    early    = run && (cnt == CNT_W'(PRE_CLKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= DEF_FIRST;
    end else if (restart) begin
      cnt <= firstPer - 1'b1;
    end else if (run) begin
      if (cnt == '0) cnt <= basePer - 1'b1;
      else           cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cs_control.sv
`timescale 1ns/1ps
module cs_control
  import convseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrite,
  input  logic [1:0] modeIn,
  input  logic [1:0] chanIn,
  input  logic       dataRead,
  input  logic       readBusy,
  input  logic       streamRd,
  input  logic       due,
  input  logic       early,
  output logic       restart,
  output logic       running,
  output strobeT     strobe,
  output logic       ready,
  output logic [1:0] chanReg
);

  stateE state;
  logic  singleMode;
  logic  chanMove;
  logic  fire;
  logic  keepOld;

  always_comb begin
    running         = (state == ST_RUN);
    chanMove        = (chanIn != chanReg);
    restart         = cfgWrite || (chanMove && running);
    fire            = due && !restart;
    keepOld         = readBusy && !streamRd;
    strobe.latch    = fire && !keepOld;
    strobe.clearErr = cfgWrite &&
                      (modeIn == MODE_CONT || modeIn == MODE_SINGLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      singleMode <= 1'b0;
      chanReg    <= '0;
    end else begin
      chanReg <= chanIn;
      if (cfgWrite) begin
        case (modeIn)
          MODE_CONT:   begin state <= ST_RUN; singleMode <= 1'b0; end
          MODE_SINGLE: begin state <= ST_RUN; singleMode <= 1'b1; end
          default:     begin state <= ST_OFF; singleMode <= 1'b0; end
        endcase
      end else if (fire && singleMode) begin
        state <= ST_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ready <= 1'b1;
    else if (restart)      ready <= 1'b1;
    else if (strobe.latch) ready <= 1'b0;
    else if (early)        ready <= 1'b1;
    else if (dataRead)     ready <= 1'b1;
  end

endmodule

// File: rtl/cs_datapath.sv
`timescale 1ns/1ps
module cs_datapath
  import convseq_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 20,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  strobeT                     strobe,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic [DATA_W-1:0]          dataReg,
  output logic                       errReg
);

  localparam int HALF = 1 << (DATA_W - 1);
  localparam logic signed [SAMPLE_W-1:0] TOP_V = SAMPLE_W'(HALF - 1);
  localparam logic signed [SAMPLE_W-1:0] BOT_V = SAMPLE_W'(-HALF);

  logic              over;
  logic              under;
  logic [DATA_W-1:0] code;

  always_comb begin
    over  = sampleIn > TOP_V;
    under = sampleIn < BOT_V;
    if (over)       code = '1;
    else if (under) code = '0;
    else            code = {~sampleIn[DATA_W-1], sampleIn[DATA_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0;
      errReg  <= 1'b0;
    end else if (strobe.latch) begin
      dataReg <= code;
      errReg  <= over || under;
    end else if (strobe.clearErr) begin
      errReg  <= 1'b0;
    end
  end

endmodule

// File: rtl/conv_sequencer.sv
`timescale 1ns/1ps
module conv_sequencer
  import convseq_pkg::*;
#(
  parameter int unsigned TICKS_X10 = 100_000_000,
  parameter int unsigned PRE_CLKS  = 1000,
  parameter int unsigned SAMPLE_W  = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWrite,
  input  logic [1:0]                 modeIn,
  input  logic [2:0]                 rateIn,
  input  logic [1:0]                 divIn,
  input  logic [1:0]                 chanIn,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       dataRead,
  input  logic                       readBusy,
  input  logic                       streamRd,
  output logic [15:0]                dataOut,
  output logic                       readyOut,
  output logic                       errOut,
  output logic [1:0]                 convChan,
  output logic                       convActive
);

  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = $clog2(16 * (TICKS_X10 / 95) + 1);

  strobeT strobe;
  logic   restart;
  logic   running;
  logic   due;
  logic   early;

  cs_timebase #(
    .TICKS_X10(TICKS_X10),
    .PRE_CLKS (PRE_CLKS),
    .CNT_W    (CNT_W)
  ) u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .run    (running),
    .rateSel(rateIn),
    .divSel (divIn),
    .due    (due),
    .early  (early)
  );

  cs_control u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfgWrite(cfgWrite),
    .modeIn  (modeIn),
    .chanIn  (chanIn),
    .dataRead(dataRead),
    .readBusy(readBusy),
    .streamRd(streamRd),
    .due     (due),
    .early   (early),
    .restart (restart),
    .running (running),
    .strobe  (strobe),
    .ready   (readyOut),
    .chanReg (convChan)
  );

  cs_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .DATA_W  (DATA_W)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .sampleIn(sampleIn),
    .dataReg (dataOut),
    .errReg  (errOut)
  );

  assign convActive = running;

endmodule

// File: rtl/cs_checker.sv
`timescale 1ns/1ps
module cs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfgWrite,
  input logic [1:0]  modeIn,
  input logic        dataRead,
  input logic [15:0] dataOut,
  input logic        readyOut,
  input logic        errOut,
  input logic        convActive
);

  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dataOut) |-> !readyOut); // R5

  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !convActive |=> $stable(dataOut)); // R8

  AST_OFF_CODES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrite && modeIn[0]) |=> !convActive); // R2

  AST_READ_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRead && !convActive) |=> readyOut); // R6

  AST_MODE_WRITE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrite |=> readyOut); // R7

  AST_ERR_AT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errOut) |-> (dataOut == 16'h0000 || dataOut == 16'hFFFF)); // R9

endmodule

bind conv_sequencer cs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfgWrite  (cfgWrite),
  .modeIn    (modeIn),
  .dataRead  (dataRead),
  .dataOut   (dataOut),
  .readyOut  (readyOut),
  .errOut    (errOut),
  .convActive(convActive)
);

// File: tb/sim_conv_sequencer.sv
`timescale 1ns/1ps
module sim_conv_sequencer;

  localparam int TB_TICKS = 12000;
  localparam int TB_PRE   = 3;
  localparam int SW       = 20;

  logic                 clk;
  logic                 rst_n;
  logic                 cfgWrite;
  logic [1:0]           modeIn;
  logic [2:0]           rateIn;
  logic [1:0]           divIn;
  logic [1:0]           chanIn;
  logic signed [SW-1:0] sampleIn;
  logic                 dataRead;
  logic                 readBusy;
  logic                 streamRd;
  logic [15:0]          dataOut;
  logic                 readyOut;
  logic                 errOut;
  logic [1:0]           convChan;
  logic                 convActive;

  int checks = 0;
  int errs   = 0;
  int expData = 0;

  conv_sequencer #(
    .TICKS_X10(TB_TICKS),
    .PRE_CLKS (TB_PRE),
    .SAMPLE_W (SW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .modeIn(modeIn),
    .rateIn(rateIn), .divIn(divIn), .chanIn(chanIn), .sampleIn(sampleIn),
    .dataRead(dataRead), .readBusy(readBusy), .streamRd(streamRd),
    .dataOut(dataOut), .readyOut(readyOut), .errOut(errOut),
    .convChan(convChan), .convActive(convActive)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int perOf(input int rate, input int dv);
    int t;
    case (rate)
      0: t = 1200; 1: t = 1000; 2: t = 333; 3: t = 200;
      4: t = 166;  5: t = 167;  6: t = 133; default: t = 95;
    endcase
    return (TB_TICKS / t) << dv;
  endfunction

  function automatic int codeOf(input int s);
    if (s > 32767)  return 16'hFFFF;
    if (s < -32768) return 0;
    return s + 32768;
  endfunction

  function automatic int errOf(input int s);
    return (s > 32767 || s < -32768) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeMode(input logic [1:0] m);
    cfgWrite = 1'b1;
    modeIn   = m;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  // restart in continuous mode and check both sides of the first write
  task automatic runCont(input int rate, input int dv, input int s, input string req);
    int n;
    rateIn   = 3'(rate);
    divIn    = 2'(dv);
    sampleIn = SW'(s);
    writeMode(2'b00);
    n = 2 * perOf(rate, dv);
    waitN(n - 1);
    chk(req, "data before first write", int'(dataOut), expData);
    chk(req, "ready before first write", int'(readyOut), 1);
    chk("R9", "err cleared by mode write", int'(errOut), 0);
    waitN(1);
    expData = codeOf(s);
    chk(req, "data at first write", int'(dataOut), expData);
    chk("R5", "ready at write", int'(readyOut), 0);
    chk("R9", "err at write", int'(errOut), errOf(s));
  endtask

  initial begin
    #1200000;
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int s;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfgWrite = 1'b0; modeIn = 2'b00; rateIn = 3'd4; divIn = 2'd0;
    chanIn = 2'd0; sampleIn = '0; dataRead = 1'b0; readBusy = 1'b0; streamRd = 1'b0;
    waitN(3);
    rst_n = 1'b1;
    waitN(1);
    // R1 reset state
    chk("R1", "data", int'(dataOut), 0);
    chk("R1", "ready", int'(readyOut), 1);
    chk("R1", "err", int'(errOut), 0);
    chk("R1", "chan", int'(convChan), 0);
    chk("R1", "active", int'(convActive), 1);

    // R3 R10 first write, then pre-window and next period at rate 0 (P=10)
    runCont(0, 0, 100, "R3");
    sampleIn = SW'(-500);
    waitN(6);
    chk("R5", "ready before pre-window", int'(readyOut), 0);
    waitN(1);
    chk("R5", "ready in pre-window", int'(readyOut), 1);
    waitN(2);
    chk("R3", "data before second write", int'(dataOut), expData);
    waitN(1);
    expData = codeOf(-500);
    chk("R10", "second write offset binary", int'(dataOut), expData);
    chk("R5", "ready after second write", int'(readyOut), 0);
    // R6 read strobe
    waitN(2);
    dataRead = 1'b1;
    waitN(1);
    dataRead = 1'b0;
    chk("R6", "ready after read", int'(readyOut), 1);
    chk("R6", "data kept after read", int'(dataOut), expData);

    // R4 divide scaling
    runCont(0, 3, 1234, "R4");

    // R9 R10 clamp boundaries
    runCont(0, 0, 32767, "R10");
    runCont(0, 0, -32768, "R10");
    runCont(0, 0, 0, "R10");
    runCont(0, 0, 32768, "R9");
    runCont(0, 0, -32769, "R9");

    // R3 R4 R9 random rate, divide and sample
    for (int i = 0; i < 12; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        s = 32768 + int'($urandom_range(0, 100000));
        if ($urandom_range(0, 1) == 1) s = -s - 1;
      end else begin
        s = int'($urandom_range(0, 65535)) - 32768;
      end
      runCont(int'($urandom_range(0, 7)), int'($urandom_range(0, 2)), s, "R3");
    end

    // R7 channel change mid-period restarts timing
    runCont(0, 0, 777, "R7");
    waitN(5);
    chanIn   = 2'd2;
    sampleIn = SW'(-9000);
    waitN(1);
    chk("R7", "ready after channel change", int'(readyOut), 1);
    chk("R7", "channel reported", int'(convChan), 2);
    waitN(19);
    chk("R7", "old schedule suppressed", int'(dataOut), expData);
    waitN(1);
    expData = codeOf(-9000);
    chk("R7", "write after channel restart", int'(dataOut), expData);
    chanIn = 2'd0;
    waitN(1);

    // R8 single conversion
    rateIn = 3'd0; divIn = 2'd0; sampleIn = SW'(4321);
    writeMode(2'b10);
    waitN(19);
    chk("R8", "single data before write", int'(dataOut), expData);
    chk("R8", "single active", int'(convActive), 1);
    waitN(1);
    expData = codeOf(4321);
    chk("R8", "single result", int'(dataOut), expData);
    chk("R8", "single ready low", int'(readyOut), 0);
    chk("R8", "single inactive", int'(convActive), 0);
    sampleIn = SW'(-4321);
    waitN(35);
    chk("R8", "single result held", int'(dataOut), expData);
    chk("R8", "single ready held low", int'(readyOut), 0);
    dataRead = 1'b1;
    waitN(1);
    dataRead = 1'b0;
    chk("R6", "ready after single read", int'(readyOut), 1);
    waitN(30);
    chk("R8", "no second single result", int'(dataOut), expData);

    // R2 power-down and reserved codes
    writeMode(2'b11);
    chk("R2", "power-down ready", int'(readyOut), 1);
    chk("R2", "power-down inactive", int'(convActive), 0);
    waitN(60);
    chk("R2", "power-down data held", int'(dataOut), expData);
    writeMode(2'b01);
    chk("R2", "reserved inactive", int'(convActive), 0);
    waitN(40);
    chk("R2", "reserved data held", int'(dataOut), expData);

    // R11 busy read keeps old word, stream mode replaces
    readBusy = 1'b1;
    streamRd = 1'b0;
    rateIn = 3'd0; divIn = 2'd0; sampleIn = SW'(2000);
    writeMode(2'b00);
    waitN(20);
    chk("R11", "busy read keeps word", int'(dataOut), expData);
    chk("R11", "ready stays high on dropped write", int'(readyOut), 1);
    streamRd = 1'b1;
    waitN(10);
    expData = codeOf(2000);
    chk("R11", "stream read replaces word", int'(dataOut), expData);
    readBusy = 1'b0;
    streamRd = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule